// File: doc/BRIEF.md
# Shared Fused Floating-Point Adder Tree

This block adds a vector of unnormalised floating-point product terms into one BFloat16 value without rounding or normalising any intermediate sum. Every lane carries a sign, an 8-bit biased exponent and a wide unsigned significand. The block works in three steps. It finds the largest exponent among the enabled lanes. It shifts every significand right by that lane's distance from the maximum. It then adds the aligned two's-complement values in a binary integer tree. One normaliser at the end finds the leading one of the magnitude, builds a single-precision-width intermediate and truncates it to BFloat16.

Two producer arrays share the tree, and each one presents its vector on different cycles. A one-bit source tag goes in with every vector and comes back with its result. The caller can therefore separate the two accumulations by their arrival cycle. The pipeline accepts one vector per cycle and returns each result a fixed two cycles later.

Top module: `bf16_fused_sum`

## Requirements
- R1: While reset is high and on the first cycle after it falls, out_valid is 0, out_value is 16'h0000 and out_src is 0.
- R2: A vector that is accepted with in_valid high at a rising clock edge gives exactly one result, and out_valid is high exactly two rising edges later. Vectors can arrive on consecutive cycles.
- R3: The out_src bit that comes with a result equals the in_src bit of the vector that produced it, including when the two source values alternate on every cycle.
- R4: Lane i uses in_sign[i], in_exp[8*i+:8] and in_sig[SIG_W*i+:SIG_W]. Its value is (-1)^sign × sig × 2^(exp − 127 − FRAC_W), with FRAC_W = 14 at SIG_W = 16. The result is the sum of the enabled lanes after alignment.
- R5: Each enabled significand is shifted right by (maximum exponent − lane exponent) before the sum, and the bits shifted out are lost. A lane whose shift is SIG_W or more adds nothing.
- R6: A lane whose in_lane_vld bit is 0 is left out of both the maximum-exponent search and the sum, whatever its exponent and significand.
- R7: A sum of exactly zero gives 16'h0000, with no negative zero. This includes a vector in which no lane is enabled.
- R8: The output is BFloat16 with the sign in bit 15, the exponent in bits 14:7 and the fraction in bits 6:0. If p is the index of the leading one of |sum|, the exponent is max exponent + p − FRAC_W and the fraction is the 7 bits just below that leading one, truncated.
- R9: The result sign comes from the two's-complement sum. A negative sum sets bit 15 and encodes its magnitude.
- R10: While out_valid is low, out_value and out_src keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A vector is presented this cycle |
| in_src | input | 1 | Producer array tag of the vector |
| in_lane_vld | input | LANES | Per-lane enable |
| in_sign | input | LANES | Per-lane sign |
| in_exp | input | LANES*8 | Per-lane biased exponent, lane i at bits 8*i+:8 |
| in_sig | input | LANES*SIG_W | Per-lane significand with FRAC_W fraction bits |
| out_valid | output | 1 | A result is presented |
| out_src | output | 1 | Producer array tag of the result |
| out_value | output | 16 | BFloat16 sum |

## Verification
On every cycle, the assertions check the two-cycle result timing and the source tag that travels with each result. They also check that a vector with no enabled lane gives +0, that no negative zero ever appears, and that the outputs hold between results. The numeric behaviour cannot be checked cycle by cycle, because it needs an independent arithmetic model. This covers alignment truncation, the exclusion of masked lanes from the maximum, the carry growth across lanes, sign handling and the exact exponent and fraction fields. Only the bench's directed vectors and its sweep over a four-lane instance show that behaviour.

// File: rtl/fsum_pkg.sv
package fsum_pkg;

    localparam int EXP_W       = 8;
    localparam int BF_FRAC_W   = 7;
    localparam int WIDE_FRAC_W = 23;

    typedef struct packed {
        logic                 sign;
        logic [EXP_W-1:0]     exp;
        logic [BF_FRAC_W-1:0] frac;
    } bf16_t;

    typedef struct packed {
        logic                   sign;
        logic [EXP_W-1:0]       exp;
        logic [WIDE_FRAC_W-1:0] frac;
    } wide_fp_t;

    function automatic int tree_levels(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

endpackage

// File: rtl/fsum_tree.sv
// Balanced binary reduction tree: a parameter selects the maximum or the sum.
// Leaves are padded to a power of two; node 0 is the root.
module fsum_tree #(
    parameter int N      = 32,
    parameter int W      = 8,
    parameter bit DO_MAX = 1'b0
) (
    input  logic [N-1:0][W-1:0] leaf_i,
    output logic [W-1:0]        root_o
);
    localparam int LVL    = fsum_pkg::tree_levels(N);
    localparam int LEAVES = 1 << LVL;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [LEAVES-1:0][W-1:0] padded;
    logic [W-1:0]             node [NODES];

    always_comb begin
        padded        = '0;
        padded[N-1:0] = leaf_i;
    end

    generate
        if (DO_MAX) begin : g_max
            always_comb begin
                for (int j = 0; j < LEAVES; j++) node[LEAVES-1+j] = padded[j];
                for (int i = LEAVES - 2; i >= 0; i--)
                    node[i] = (node[2*i+1] > node[2*i+2]) ? node[2*i+1] : node[2*i+2];
            end
        end else begin : g_add
            always_comb begin
                for (int j = 0; j < LEAVES; j++) node[LEAVES-1+j] = padded[j];
                for (int i = LEAVES - 2; i >= 0; i--)
                    node[i] = node[2*i+1] + node[2*i+2];
            end
        end
    endgenerate

    assign root_o = node[0];
endmodule

// File: rtl/fsum_align.sv
// Per-lane alignment against the global maximum exponent and signed conversion.
module fsum_align
    import fsum_pkg::*;
#(
    parameter int LANES = 32,
    parameter int SIG_W = 16,
    parameter int SUM_W = 22
) (
    input  logic [EXP_W-1:0]              max_exp_i,
    input  logic [LANES-1:0]              lane_vld_i,
    input  logic [LANES-1:0]              sign_i,
    input  logic [LANES-1:0][EXP_W-1:0]   exp_i,
    input  logic [LANES-1:0][SIG_W-1:0]   sig_i,
    output logic [LANES-1:0][SUM_W-1:0]   aligned_o
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [EXP_W-1:0] diff;
            logic [SIG_W-1:0] shifted;
            logic [SUM_W-1:0] ext;
            logic [SUM_W-1:0] lane_val;

            always_comb begin
                diff    = max_exp_i - exp_i[l];
                shifted = (int'(diff) >= SIG_W) ? '0 : (sig_i[l] >> diff);
                ext     = {{(SUM_W-SIG_W){1'b0}}, shifted};
                if (!lane_vld_i[l])
                    lane_val = '0;
                else if (sign_i[l])
                    lane_val = -ext;
                else
                    lane_val = ext;
            end

            assign aligned_o[l] = lane_val;
        end
    endgenerate
endmodule

// File: rtl/fsum_norm.sv
// Single output normaliser: leading-one search, wide intermediate, truncation.
module fsum_norm
    import fsum_pkg::*;
#(
    parameter int SUM_W  = 22,
    parameter int FRAC_W = 14
) (
    input  logic [SUM_W-1:0] sum_i,
    input  logic [EXP_W-1:0] max_exp_i,
    output bf16_t            res_o
);
    localparam int LEAD_W = $clog2(SUM_W);
    localparam int BODY_W = SUM_W - 1;

    logic                   neg;
    logic [SUM_W-1:0]       mag;
    logic [LEAD_W-1:0]      lead;
    logic [BODY_W-1:0]      body;
    logic [WIDE_FRAC_W-1:0] frac_full;
    int                     e_tmp;
    wide_fp_t               wide;
    logic                   unused_frac_lo;

    always_comb begin
        neg  = sum_i[SUM_W-1];
        mag  = neg ? -sum_i : sum_i;
        lead = '0;
        for (int b = 0; b < SUM_W; b++)
            if (mag[b]) lead = LEAD_W'(b);
        // Put the leading one just above the kept field, then drop it.
        body  = BODY_W'(mag << (SUM_W - 1 - int'(lead)));
        e_tmp = int'(max_exp_i) + int'(lead) - FRAC_W;
    end

    generate
        if (BODY_W >= WIDE_FRAC_W) begin : g_cut
            logic unused_body_tail;
            assign frac_full        = body[BODY_W-1 -: WIDE_FRAC_W];
            assign unused_body_tail = ^body;
        end else begin : g_pad
            assign frac_full = {body, {(WIDE_FRAC_W-BODY_W){1'b0}}};
        end
    endgenerate

    always_comb begin
        if (mag == '0) begin
            wide = '0;
        end else begin
            wide.sign = neg;
            wide.exp  = EXP_W'(e_tmp);
            wide.frac = frac_full;
        end
        res_o.sign = wide.sign;
        res_o.exp  = wide.exp;
        res_o.frac = wide.frac[WIDE_FRAC_W-1 -: BF_FRAC_W];
    end

    assign unused_frac_lo = ^wide.frac[WIDE_FRAC_W-BF_FRAC_W-1:0];
endmodule

// File: rtl/bf16_fused_sum.sv
// Two-stage fused sum: stage 1 = max exponent + alignment,
// stage 2 = integer tree + single normalisation.
module bf16_fused_sum
    import fsum_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int SIG_W  = 16,
    parameter int FRAC_W = 14
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_src,
    input  logic [LANES-1:0]       in_lane_vld,
    input  logic [LANES-1:0]       in_sign,
    input  logic [LANES*EXP_W-1:0] in_exp,
    input  logic [LANES*SIG_W-1:0] in_sig,
    output logic                   out_valid,
    output logic                   out_src,
    output logic [15:0]            out_value
);
    localparam int LOG_L = tree_levels(LANES);
    localparam int SUM_W = SIG_W + 1 + LOG_L;

    // ---------------- stage 1 ----------------
    logic [LANES-1:0][EXP_W-1:0] lane_exp;
    logic [LANES-1:0][EXP_W-1:0] exp_leaf;
    logic [LANES-1:0][SIG_W-1:0] lane_sig;
    logic [EXP_W-1:0]            max_exp;
    logic [LANES-1:0][SUM_W-1:0] aligned;

    assign lane_exp = in_exp;
    assign lane_sig = in_sig;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_leaf
            assign exp_leaf[l] = in_lane_vld[l] ? lane_exp[l] : '0;
        end
    endgenerate

    fsum_tree #(.N(LANES), .W(EXP_W), .DO_MAX(1'b1)) u_max_tree (
        .leaf_i (exp_leaf),
        .root_o (max_exp)
    );

    fsum_align #(.LANES(LANES), .SIG_W(SIG_W), .SUM_W(SUM_W)) u_align (
        .max_exp_i  (max_exp),
        .lane_vld_i (in_lane_vld),
        .sign_i     (in_sign),
        .exp_i      (lane_exp),
        .sig_i      (lane_sig),
        .aligned_o  (aligned)
    );

    logic                        s1_valid;
    logic                        s1_src;
    logic [EXP_W-1:0]            s1_max;
    logic [LANES-1:0][SUM_W-1:0] s1_aligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_src     <= 1'b0;
            s1_max     <= '0;
            s1_aligned <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_src     <= in_src;
                s1_max     <= max_exp;
                s1_aligned <= aligned;
            end
        end
    end

    // ---------------- stage 2 ----------------
    logic [SUM_W-1:0] total;
    bf16_t            result;
    bf16_t            out_q;

    fsum_tree #(.N(LANES), .W(SUM_W), .DO_MAX(1'b0)) u_sum_tree (
        .leaf_i (s1_aligned),
        .root_o (total)
    );

    fsum_norm #(.SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_norm (
        .sum_i     (total),
        .max_exp_i (s1_max),
        .res_o     (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_src   <= 1'b0;
            out_q     <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_src <= s1_src;
                out_q   <= result;
            end
        end
    end

    assign out_value = out_q;
endmodule

// File: rtl/fsum_checker.sv
module fsum_checker #(
    parameter int LANES = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_src,
    input logic [LANES-1:0] in_lane_vld,
    input logic             out_valid,
    input logic             out_src,
    input logic [15:0]      out_value
);
    // Cycles since reset, saturating; keeps $past windows inside post-reset history.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_value == 16'h0000 && !out_src));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_src_tag_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> (out_src == $past(in_src, 2)));

    p_masked_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid && $past(in_lane_vld, 2) == '0) |-> (out_value == 16'h0000));

    p_no_neg_zero_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_value != 16'h8000));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |-> ($stable(out_value) && $stable(out_src)));
endmodule

bind bf16_fused_sum fsum_checker #(.LANES(LANES)) u_fsum_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_src      (in_src),
    .in_lane_vld (in_lane_vld),
    .out_valid   (out_valid),
    .out_src     (out_src),
    .out_value   (out_value)
);

// File: tb/tb_bf16_fused_sum.sv
module tb_bf16_fused_sum;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 4;
    localparam int SW = 16;
    localparam int EW = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_src;
    logic [L-1:0]    in_lane_vld;
    logic [L-1:0]    in_sign;
    logic [L*EW-1:0] in_exp;
    logic [L*SW-1:0] in_sig;
    logic            out_valid;
    logic            out_src;
    logic [15:0]     out_value;

    bf16_fused_sum #(.LANES(L), .SIG_W(SW), .FRAC_W(14)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
        .in_lane_vld(in_lane_vld), .in_sign(in_sign), .in_exp(in_exp),
        .in_sig(in_sig), .out_valid(out_valid), .out_src(out_src),
        .out_value(out_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] val;
        logic        src;
        int          stamp;
        string       tag;
    } expect_t;

    expect_t     pend[$];
    logic [15:0] last_val = 16'h0000;
    logic        last_src = 1'b0;
    logic [31:0] seed = 32'h1F2E_3D4C;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Arithmetic reference: value of each lane is sig * 2^(exp-127-14).
    function automatic logic [15:0] model(input logic [L-1:0] v, input logic [L-1:0] s,
                                          input logic [L*EW-1:0] e, input logic [L*SW-1:0] m);
        int     mx;
        longint acc;
        longint mag;
        longint part;
        int     d;
        int     p;
        int     eo;
        longint fr;
        mx = 0;
        for (int i = 0; i < L; i++)
            if (v[i] && int'(e[i*EW +: EW]) > mx) mx = int'(e[i*EW +: EW]);
        acc = 0;
        for (int i = 0; i < L; i++) begin
            if (v[i]) begin
                d = mx - int'(e[i*EW +: EW]);
                if (d >= SW) part = 0;
                else part = longint'(m[i*SW +: SW]) / (longint'(1) << d);
                acc = s[i] ? acc - part : acc + part;
            end
        end
        if (acc == 0) return 16'h0000;
        mag = (acc < 0) ? -acc : acc;
        p = 0;
        while ((mag >> (p + 1)) != 0) p++;
        eo = mx + p - 14;
        fr = ((mag << 7) >> p) & 127;
        return {acc < 0, eo[7:0], fr[6:0]};
    endfunction

    task automatic observe();
        expect_t e;
        if (out_valid) begin
            if (pend.size() == 0) begin
                chk(1'b0, "R2", "result without vector", 32'd1, 32'd0);
            end else begin
                e = pend.pop_front();
                chk((cyc - e.stamp) == 2, "R2", "latency", 32'(cyc - e.stamp), 32'd2);
                chk(out_src == e.src, "R3", "source tag", 32'(out_src), 32'(e.src));
                chk(out_value == e.val, e.tag, "sum value", 32'(out_value), 32'(e.val));
            end
            last_val = out_value;
            last_src = out_src;
        end else begin
            chk(out_value == last_val && out_src == last_src, "R10", "hold while idle",
                {15'd0, out_src, out_value}, {15'd0, last_src, last_val});
            if (pend.size() > 0 && (cyc - pend[0].stamp) >= 2)
                chk(1'b0, "R2", "missing result", 32'd0, 32'd1);
        end
    endtask

    task automatic step(input bit vld, input logic [L-1:0] v, input logic [L-1:0] s,
                        input logic [L*EW-1:0] e, input logic [L*SW-1:0] m,
                        input logic src, input string tag,
                        input bit use_lit, input logic [15:0] lit);
        expect_t x;
        @(negedge clk);
        observe();
        in_valid    = vld;
        in_lane_vld = v;
        in_sign     = s;
        in_exp      = e;
        in_sig      = m;
        in_src      = src;
        if (vld) begin
            x.val   = use_lit ? lit : model(v, s, e, m);
            x.src   = src;
            x.stamp = cyc;
            x.tag   = tag;
            pend.push_back(x);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++)
            step(1'b0, '0, '0, '0, '0, 1'b0, "", 1'b0, 16'h0);
    endtask

    task automatic rand_vec(output logic [L-1:0] v, output logic [L-1:0] s,
                            output logic [L*EW-1:0] e, output logic [L*SW-1:0] m);
        logic [31:0] r;
        for (int i = 0; i < L; i++) begin
            r = rnd();
            v[i] = (r[1:0] != 2'b00);
            s[i] = r[2];
            if (r[11:8] == 4'd0) e[i*EW +: EW] = 8'(60 + int'(r[15:12]));
            else e[i*EW +: EW] = 8'(100 + (int'(r[7:3]) % 24));
            m[i*SW +: SW] = r[31:16];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [L-1:0]    v;
        logic [L-1:0]    s;
        logic [L*EW-1:0] e;
        logic [L*SW-1:0] m;

        rst         = 1'b1;
        in_valid    = 1'b1;
        in_src      = 1'b1;
        in_lane_vld = '1;
        in_sign     = '0;
        in_exp      = {L{8'd127}};
        in_sig      = {L{16'h4000}};
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid during reset", 32'(out_valid), 32'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'd0);
        chk(out_value == 16'h0000, "R1", "value after reset", 32'(out_value), 32'd0);
        chk(out_src == 1'b0, "R1", "src after reset", 32'(out_src), 32'd0);

        // R4: single lane 1.0 -> 0x3F80
        step(1, 4'b0001, 4'b0000, {8'd0, 8'd0, 8'd0, 8'd127},
             {16'h0, 16'h0, 16'h0, 16'h4000}, 0, "R4", 1, 16'h3F80);
        // R8: 1.5 at exponent 130 -> 12.0 = 0x4140
        step(1, 4'b0001, 4'b0000, {8'd0, 8'd0, 8'd0, 8'd130},
             {16'h0, 16'h0, 16'h0, 16'h6000}, 1, "R8", 1, 16'h4140);
        // R9: -1.5 + 1.0 -> -0.5 = 0xBF00
        step(1, 4'b0011, 4'b0001, {8'd0, 8'd0, 8'd127, 8'd127},
             {16'h0, 16'h0, 16'h4000, 16'h6000}, 0, "R9", 1, 16'hBF00);
        idle(2);
        // R6: masked lane with huge exponent must not move the maximum
        step(1, 4'b1101, 4'b0000, {8'd0, 8'd0, 8'd250, 8'd127},
             {16'h0, 16'h0, 16'hFFFF, 16'h4000}, 1, "R6", 1, 16'h3F80);
        // R7: no lane enabled -> +0
        step(1, 4'b0000, 4'b1111, {8'd200, 8'd201, 8'd202, 8'd203},
             {16'hFFFF, 16'h1234, 16'h8000, 16'h7777}, 0, "R7", 1, 16'h0000);
        // R7: exact cancellation -> +0
        step(1, 4'b0011, 4'b0010, {8'd0, 8'd0, 8'd127, 8'd127},
             {16'h0, 16'h0, 16'h6000, 16'h6000}, 1, "R7", 1, 16'h0000);
        // R5: shift of exactly 16 drops the lane
        step(1, 4'b0011, 4'b0000, {8'd0, 8'd0, 8'd134, 8'd150},
             {16'h0, 16'h0, 16'hFFFF, 16'h4000}, 0, "R5", 1, 16'h4B00);
        // R5: shift of 7 keeps 511 of the lane
        step(1, 4'b0011, 4'b0000, {8'd0, 8'd0, 8'd143, 8'd150},
             {16'h0, 16'h0, 16'hFFFF, 16'h4000}, 1, "R5", 1, 16'h4B03);
        // R8: carry growth across all lanes -> 0x417F
        step(1, 4'b1111, 4'b0000, {8'd127, 8'd127, 8'd127, 8'd127},
             {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, 0, "R8", 1, 16'h417F);
        idle(3);

        // R3: two producers alternating back to back
        for (int k = 0; k < 40; k++) begin
            rand_vec(v, s, e, m);
            step(1, v, s, e, m, k[0], "R3", 0, 16'h0);
        end
        idle(3);

        // R4 sweep with random gaps and random source tags (R2, R10 on gaps)
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = rnd();
            if (r[3:0] == 4'd0) idle(1 + int'(r[5:4]));
            rand_vec(v, s, e, m);
            step(1, v, s, e, m, r[6], "R4", 0, 16'h0);
        end
        idle(4);
        chk(pend.size() == 0, "R2", "results outstanding", 32'(pend.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule